// File: doc/BRIEF.md
# Multi-queue stored packet replay engine

The engine holds a small on-chip packet memory that a host fills through a plain write port, one stream beat per word (data, byte keep, end-of-packet flag and user sideband). Up to four replay queues each own a window of that memory, bounded by a low and a high word address. When a queue is started, it walks its window in ascending address order, wraps from the high address back to the low address, and repeats the window a programmed number of times. Each beat leaves on the AXI4-Stream egress channel named by a two-bit destination field in its user sideband.

The queues share the single memory read port. A round-robin arbiter hands the port to one queue per packet, so packets from different queues never interleave on a channel. Backpressure on the selected channel stalls the owning queue with the beat held steady.

Control sits behind an AXI4-Lite slave. Word 0 holds a level-sensitive soft reset. The remaining words hold per-queue start triggers, repeat counts, window bounds and enables.

Top module: `pkt_replay`

## Requirements
- R1: Parameter NQ (1 to 4) sets the number of egress channels. A beat leaves on the channel equal to its user bits [DEST_POS+1:DEST_POS]. A beat whose field is NQ or more is consumed and dropped, and no channel signals valid for it.
- R2: The register byte offsets are: 0x00 soft reset (bit 0); 0x04+4q start (bit 0); 0x14+4q repeat count; 0x24+8q window low; 0x28+8q window high; 0x44+4q enable (bit 0). Every register reads back the last value written, zero-extended.
- R3: While the soft reset bit is 1, no channel signals valid and every running replay is abandoned. Clearing the bit resumes nothing.
- R4: Writing 1 to a queue's start bit when it holds 0 begins a replay from the window low address. This happens only if the queue is enabled and its count is nonzero. A start write while that queue is replaying is ignored.
- R5: A replay emits the words from the low address through the high address, inclusive, in ascending order. It repeats the window exactly the programmed count of times and then goes idle.
- R6: A repeat count of 0 makes a start produce no output.
- R7: With its enable bit at 0, a queue ignores start writes and emits nothing.
- R8: While a channel has valid high and ready low, valid stays high and data, keep, last and user stay unchanged.
- R9: The read port passes between running queues in round-robin order, and only after a beat with last set (or when a queue finishes). No other queue's beat appears between the first and last beat of a packet.
- R10: An AXI4-Lite write is accepted when address and data are both valid and no response is pending. The response is valid on the following cycle. Read data is valid the cycle after the address is accepted and is held until taken.
- R11: After reset no channel signals valid and all registers read 0.
- R12: At most one egress channel signals valid in any cycle.
- R13: The host write port stores a beat at the given address, and that beat can be replayed on any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_we | input | 1 | Packet memory write strobe |
| mem_waddr | input | AW | Packet memory word address |
| mem_wdata | input | DW | Beat data to store |
| mem_wkeep | input | DW/8 | Beat byte keep to store |
| mem_wlast | input | 1 | Beat end-of-packet flag to store |
| mem_wuser | input | UW | Beat user sideband to store |
| s_awaddr | input | LAW | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | LAW | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| m_tdata | output | NQ*DW | Egress data, DW bits per channel |
| m_tkeep | output | NQ*DW/8 | Egress byte keep per channel |
| m_tlast | output | NQ | Egress end-of-packet per channel |
| m_tuser | output | NQ*UW | Egress user sideband per channel |
| m_tvalid | output | NQ | Egress valid per channel |
| m_tready | input | NQ | Egress ready per channel |

## Verification
The bench builds the engine with three queues, 16-bit data, the destination field at user bit 4, a 32-word memory and 4-bit counts. With three channels, a destination value of 3 names a channel that does not exist, so the drop path is reachable from stored packets alone. The raised field position shows that routing reads the right user bits. The short window and count widths keep wrap and multi-pass sequences within a few dozen cycles. Channel-by-channel ready control lets one queue be held mid-packet while another is started, which exposes both the ignored-restart case and the packet-boundary handover.

// File: rtl/pkt_replay.sv
module pkt_replay #(
  parameter int NQ       = 4,
  parameter int DW       = 32,
  parameter int UW       = 8,
  parameter int DEST_POS = 0,
  parameter int AW       = 6,
  parameter int CW       = 8,
  parameter int LAW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_we,
  input  logic [AW-1:0]      mem_waddr,
  input  logic [DW-1:0]      mem_wdata,
  input  logic [DW/8-1:0]    mem_wkeep,
  input  logic               mem_wlast,
  input  logic [UW-1:0]      mem_wuser,
  input  logic [LAW-1:0]     s_awaddr,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [31:0]        s_wdata,
  input  logic               s_wvalid,
  output logic               s_wready,
  output logic [1:0]         s_bresp,
  output logic               s_bvalid,
  input  logic               s_bready,
  input  logic [LAW-1:0]     s_araddr,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [31:0]        s_rdata,
  output logic [1:0]         s_rresp,
  output logic               s_rvalid,
  input  logic               s_rready,
  output logic [NQ*DW-1:0]   m_tdata,
  output logic [NQ*DW/8-1:0] m_tkeep,
  output logic [NQ-1:0]      m_tlast,
  output logic [NQ*UW-1:0]   m_tuser,
  output logic [NQ-1:0]      m_tvalid,
  input  logic [NQ-1:0]      m_tready
);
  localparam int KW = DW / 8;
  localparam int MW = DW + KW + 1 + UW;
  localparam int RW = LAW - 2;

  logic [MW-1:0] mem [2**AW];

  logic          soft_q;
  logic          start_q [NQ];
  logic          en_q    [NQ];
  logic [CW-1:0] cnt_q   [NQ];
  logic [AW-1:0] lo_q    [NQ];
  logic [AW-1:0] hi_q    [NQ];
  logic [NQ-1:0] run;
  logic [AW-1:0] ptr     [NQ];
  logic [CW-1:0] rem     [NQ];

  logic       lock, pick_ok;
  logic [1:0] cur, last, pick;

  logic [MW-1:0] beat;
  logic [DW-1:0] b_data;
  logic [KW-1:0] b_keep;
  logic          b_last;
  logic [UW-1:0] b_user;
  logic [1:0]    dest;
  logic          live, dest_ok, fire, wrap, done;

  logic          wr;
  logic [RW-1:0] wi, ri;
  logic [31:0]   rd;
  logic          unused_bits;

  assign unused_bits = ^{s_awaddr[1:0], s_araddr[1:0], s_wdata};

  always_ff @(posedge clk)
    if (mem_we) mem[mem_waddr] <= {mem_wuser, mem_wlast, mem_wkeep, mem_wdata};

  assign beat    = mem[ptr[cur]];
  assign b_data  = beat[DW-1:0];
  assign b_keep  = beat[DW +: KW];
  assign b_last  = beat[DW+KW];
  assign b_user  = beat[DW+KW+1 +: UW];
  assign dest    = b_user[DEST_POS +: 2];
  assign live    = lock && run[cur];
  assign dest_ok = int'(dest) < NQ;
  assign fire    = live && (!dest_ok || m_tready[dest]);
  assign wrap    = ptr[cur] == hi_q[cur];
  assign done    = wrap && rem[cur] == CW'(1);

  for (genvar c = 0; c < NQ; c++) begin : g_ch
    assign m_tvalid[c]          = live && dest_ok && dest == 2'(c);
    assign m_tdata[c*DW +: DW]  = b_data;
    assign m_tkeep[c*KW +: KW]  = b_keep;
    assign m_tlast[c]           = b_last;
    assign m_tuser[c*UW +: UW]  = b_user;
  end

  always_comb begin
    pick    = last;
    pick_ok = 1'b0;
    for (int k = 1; k <= NQ; k++)
      if (!pick_ok && run[(int'(last) + k) % NQ]) begin
        pick_ok = 1'b1;
        pick    = 2'((int'(last) + k) % NQ);
      end
  end

  assign wr        = s_awvalid && s_wvalid && !s_bvalid;
  assign s_awready = wr;
  assign s_wready  = wr;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign s_arready = !s_rvalid;
  assign wi        = s_awaddr[LAW-1:2];
  assign ri        = s_araddr[LAW-1:2];

  always_comb begin
    rd = 32'd0;
    if (ri == '0) rd = {31'd0, soft_q};
    for (int q = 0; q < NQ; q++) begin
      if (int'(ri) == 1 + q)     rd = {31'd0, start_q[q]};
      if (int'(ri) == 5 + q)     rd = 32'(cnt_q[q]);
      if (int'(ri) == 9 + 2*q)   rd = 32'(lo_q[q]);
      if (int'(ri) == 10 + 2*q)  rd = 32'(hi_q[q]);
      if (int'(ri) == 17 + q)    rd = {31'd0, en_q[q]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_q   <= 1'b0;
      s_bvalid <= 1'b0;
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
      lock     <= 1'b0;
      cur      <= '0;
      last     <= 2'(NQ - 1);
      run      <= '0;
      for (int q = 0; q < NQ; q++) begin
        start_q[q] <= 1'b0;
        en_q[q]    <= 1'b0;
        cnt_q[q]   <= '0;
        lo_q[q]    <= '0;
        hi_q[q]    <= '0;
        ptr[q]     <= '0;
        rem[q]     <= '0;
      end
    end else begin
      if (wr) s_bvalid <= 1'b1;
      else if (s_bready) s_bvalid <= 1'b0;

      if (s_arvalid && !s_rvalid) begin
        s_rvalid <= 1'b1;
        s_rdata  <= rd;
      end else if (s_rready) s_rvalid <= 1'b0;

      if (wr && wi == '0) soft_q <= s_wdata[0];

      for (int q = 0; q < NQ; q++) begin
        if (wr) begin
          if (int'(wi) == 1 + q)    start_q[q] <= s_wdata[0];
          if (int'(wi) == 5 + q)    cnt_q[q]   <= s_wdata[CW-1:0];
          if (int'(wi) == 9 + 2*q)  lo_q[q]    <= s_wdata[AW-1:0];
          if (int'(wi) == 10 + 2*q) hi_q[q]    <= s_wdata[AW-1:0];
          if (int'(wi) == 17 + q)   en_q[q]    <= s_wdata[0];
        end

        if (soft_q) run[q] <= 1'b0;
        else if (fire && cur == 2'(q)) begin
          ptr[q] <= wrap ? lo_q[q] : ptr[q] + AW'(1);
          if (wrap) begin
            rem[q] <= rem[q] - CW'(1);
            if (rem[q] == CW'(1)) run[q] <= 1'b0;
          end
        end else if (wr && int'(wi) == 1 + q && s_wdata[0] && !start_q[q] &&
                     en_q[q] && cnt_q[q] != '0 && !run[q]) begin
          run[q] <= 1'b1;
          ptr[q] <= lo_q[q];
          rem[q] <= cnt_q[q];
        end
      end

      if (soft_q) lock <= 1'b0;
      else if (lock) begin
        if (!run[cur]) lock <= 1'b0;
        else if (fire && (b_last || done)) begin
          lock <= 1'b0;
          last <= cur;
        end
      end else if (pick_ok) begin
        lock <= 1'b1;
        cur  <= pick;
      end
    end
  end
endmodule

// File: rtl/pkt_replay_chk.sv
module pkt_replay_chk #(
  parameter int NQ = 4,
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_q,
  input logic [NQ-1:0]    m_tvalid,
  input logic [NQ-1:0]    m_tready,
  input logic [NQ*DW-1:0] m_tdata,
  input logic [NQ-1:0]    m_tlast,
  input logic             s_awvalid,
  input logic             s_wvalid,
  input logic             s_awready,
  input logic             s_bvalid,
  input logic             s_rvalid,
  input logic             s_rready,
  input logic [31:0]      s_rdata
);
  for (genvar c = 0; c < NQ; c++) begin : g_hold
    a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n || soft_q)
      m_tvalid[c] && !m_tready[c] |=>
        m_tvalid[c] && $stable(m_tdata[c*DW +: DW]) && $stable(m_tlast[c]));
  end

  a_r12_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_tvalid));

  a_r3_soft_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q && $past(soft_q) |-> m_tvalid == '0);

  a_r10_write_resp: assert property (@(posedge clk) disable iff (!rst_n)
    s_awvalid && s_wvalid && s_awready |=> s_bvalid);

  a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
endmodule

bind pkt_replay pkt_replay_chk #(.NQ(NQ), .DW(DW)) u_chk (.*);

// File: tb/test_pkt_replay.sv
module test_pkt_replay;
  localparam int NQ = 3, DW = 16, UW = 8, DP = 4, AW = 5, CW = 4, LAW = 8;

  // each row: queue, low, high, count
  localparam logic [15:0] VEC [5] = '{
    {2'd0, 5'd0, 5'd2, 4'd1},
    {2'd1, 5'd3, 5'd5, 4'd2},
    {2'd2, 5'd0, 5'd8, 4'd1},
    {2'd0, 5'd8, 5'd8, 4'd3},
    {2'd1, 5'd0, 5'd2, 4'd0}
  };

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic             mem_we = 0;
  logic [AW-1:0]    mem_waddr = 0;
  logic [DW-1:0]    mem_wdata = 0;
  logic [DW/8-1:0]  mem_wkeep = 0;
  logic             mem_wlast = 0;
  logic [UW-1:0]    mem_wuser = 0;
  logic [LAW-1:0]   awaddr = 0, araddr = 0;
  logic             awvalid = 0, wvalid = 0, arvalid = 0;
  logic [31:0]      wdata = 0;
  logic             awready, wready, bvalid, arready, rvalid;
  logic [1:0]       bresp, rresp;
  logic [31:0]      rdata;
  logic [NQ*DW-1:0] m_tdata;
  logic [NQ*DW/8-1:0] m_tkeep;
  logic [NQ-1:0]    m_tlast, m_tvalid;
  logic [NQ*UW-1:0] m_tuser;
  logic [NQ-1:0]    rdy = '1;

  pkt_replay #(.NQ(NQ), .DW(DW), .UW(UW), .DEST_POS(DP), .AW(AW), .CW(CW), .LAW(LAW)) i_pkt_replay (
    .clk(clk), .rst_n(rst_n),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wkeep(mem_wkeep),
    .mem_wlast(mem_wlast), .mem_wuser(mem_wuser),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tuser(m_tuser),
    .m_tvalid(m_tvalid), .m_tready(rdy));

  int n_chk = 0, n_bad = 0;
  logic [1:0]  log_ch [512];
  logic [15:0] log_d  [512];
  logic        log_l  [512];
  int log_n = 0;
  logic [1:0]  exp_ch [512];
  logic [15:0] exp_d  [512];
  logic        exp_l  [512];
  int exp_n;

  always @(posedge clk)
    if (rst_n)
      for (int c = 0; c < NQ; c++)
        if (m_tvalid[c] && rdy[c] && log_n < 512) begin
          log_ch[log_n] <= 2'(c);
          log_d[log_n]  <= m_tdata[c*DW +: DW];
          log_l[log_n]  <= m_tlast[c];
          log_n <= log_n + 1;
        end

  function automatic int dest_of(input int a);
    if (a <= 2) return 0;
    if (a <= 4) return 1;
    if (a == 5) return 2;
    if (a <= 7) return 3;
    return 0;
  endfunction

  function automatic bit last_of(input int a);
    return a == 2 || a == 4 || a == 5 || a == 7 || a == 8;
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lite_wr(input int a, input int d);
    @(negedge clk);
    awaddr = LAW'(a); wdata = d; awvalid = 1; wvalid = 1;
    while (!awready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
  endtask

  task automatic lite_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    araddr = LAW'(a); arvalid = 1;
    while (!arready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    arvalid = 0;
    d = rdata;
  endtask

  task automatic mem_put(input int a);
    @(negedge clk);
    mem_we = 1; mem_waddr = AW'(a); mem_wdata = 16'hA000 + 16'(a);
    mem_wkeep = '1; mem_wlast = last_of(a);
    mem_wuser = {2'b00, 2'(dest_of(a)), 4'(a)};
    @(negedge clk);
    mem_we = 0;
  endtask

  task automatic setup(input int q, input int lo, input int hi, input int cnt, input int en);
    lite_wr(8'h24 + 8*q, lo);
    lite_wr(8'h28 + 8*q, hi);
    lite_wr(8'h14 + 4*q, cnt);
    lite_wr(8'h44 + 4*q, en);
  endtask

  task automatic kick(input int q);
    lite_wr(8'h04 + 4*q, 0);
    lite_wr(8'h04 + 4*q, 1);
  endtask

  task automatic add_win(input int lo, input int hi, input int cnt);
    for (int r = 0; r < cnt; r++)
      for (int a = lo; a <= hi; a++)
        if (dest_of(a) < NQ) begin
          exp_ch[exp_n] = 2'(dest_of(a));
          exp_d[exp_n]  = 16'hA000 + 16'(a);
          exp_l[exp_n]  = last_of(a);
          exp_n++;
        end
  endtask

  task automatic cmp_log(input int base, input string tag);
    chk(log_n - base == exp_n, {tag, " beat count"}, log_n - base, exp_n);
    for (int i = 0; i < exp_n; i++)
      if (base + i < log_n)
        chk(log_ch[base+i] == exp_ch[i] && log_d[base+i] == exp_d[i] && log_l[base+i] == exp_l[i],
            {tag, " beat"}, {log_ch[base+i], log_l[base+i], log_d[base+i]},
            {exp_ch[i], exp_l[i], exp_d[i]});
  endtask

  initial begin
    logic [31:0] rv;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    chk(m_tvalid == '0, "R11 valid after reset", m_tvalid, 0);
    lite_rd(8'h14, rv);
    chk(rv == 0, "R11 count reg after reset", rv, 0);
    lite_rd(8'h00, rv);
    chk(rv == 0, "R11 soft reg after reset", rv, 0);

    // R13 memory load
    for (int a = 0; a <= 8; a++) mem_put(a);

    // R2 register readback, R10 write response timing
    @(negedge clk);
    awaddr = 8'h34; wdata = 17; awvalid = 1; wvalid = 1;
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk(bvalid == 1'b1, "R10 write response next cycle", bvalid, 1);
    lite_rd(8'h34, rv);
    chk(rv == 17, "R2 low addr q2 readback", rv, 17);
    lite_wr(8'h30, 9);
    lite_rd(8'h30, rv);
    chk(rv == 9, "R2 high addr q1 readback", rv, 9);
    lite_wr(8'h4C, 1);
    lite_rd(8'h4C, rv);
    chk(rv == 1, "R2 enable q2 readback", rv, 1);

    // R5 R1 R6 R13 vector table
    foreach (VEC[v]) begin
      base = log_n;
      exp_n = 0;
      setup(int'(VEC[v][15:14]), int'(VEC[v][13:9]), int'(VEC[v][8:4]), int'(VEC[v][3:0]), 1);
      kick(int'(VEC[v][15:14]));
      wait_cyc(80);
      add_win(int'(VEC[v][13:9]), int'(VEC[v][8:4]), int'(VEC[v][3:0]));
      cmp_log(base, $sformatf("R5 R1 R6 vector %0d", v));
      chk(m_tvalid == '0, "R5 idle after replay", m_tvalid, 0);
    end

    // R7 disabled queue ignores start
    base = log_n;
    setup(2, 0, 2, 1, 0);
    kick(2);
    wait_cyc(20);
    chk(log_n == base && m_tvalid == '0, "R7 disabled queue output", log_n - base, 0);

    // R8 backpressure, R4 restart ignored while running
    rdy = 3'b110;
    base = log_n;
    setup(0, 8, 8, 2, 1);
    kick(0);
    wait_cyc(3);
    chk(m_tvalid == 3'b001 && m_tdata[15:0] == 16'hA008, "R8 stalled beat shown",
        {m_tvalid, m_tdata[15:0]}, {3'b001, 16'hA008});
    wait_cyc(4);
    chk(m_tvalid == 3'b001 && m_tdata[15:0] == 16'hA008 && m_tlast[0], "R8 stalled beat held",
        {m_tvalid, m_tdata[15:0]}, {3'b001, 16'hA008});
    rdy = 3'b111;
    @(negedge clk);
    rdy = 3'b110;
    lite_wr(8'h14, 3);
    kick(0);
    rdy = 3'b111;
    wait_cyc(20);
    chk(log_n - base == 2, "R4 restart while running ignored", log_n - base, 2);

    // R9 round robin at packet boundaries
    rdy = 3'b000;
    base = log_n;
    setup(0, 0, 2, 2, 1);
    setup(1, 3, 4, 1, 1);
    kick(0);
    kick(1);
    rdy = 3'b111;
    wait_cyc(40);
    exp_n = 0;
    add_win(0, 2, 1);
    add_win(3, 4, 1);
    add_win(0, 2, 1);
    cmp_log(base, "R9 round robin order");

    // R3 soft reset
    rdy = 3'b000;
    setup(0, 0, 8, 5, 1);
    kick(0);
    wait_cyc(3);
    chk(m_tvalid == 3'b001, "R3 running before soft reset", m_tvalid, 3'b001);
    lite_wr(8'h00, 1);
    wait_cyc(2);
    chk(m_tvalid == '0, "R3 quiet under soft reset", m_tvalid, 0);
    lite_rd(8'h00, rv);
    chk(rv == 1, "R3 soft reg reads 1", rv, 1);
    base = log_n;
    lite_wr(8'h00, 0);
    rdy = 3'b111;
    wait_cyc(20);
    chk(log_n == base && m_tvalid == '0, "R3 nothing resumes", log_n - base, 0);

    // R12 channels exclusive during a mixed replay
    setup(2, 0, 8, 1, 1);
    kick(2);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk($countones(m_tvalid) <= 1, "R12 single channel valid", m_tvalid, 0);
    end
    wait_cyc(20);

    summary();
  end
endmodule